// File: doc/BRIEF.md
# Nine-bit command/data SPI framer

This block drives a display controller over a three-wire SPI link, one where no separate pin tells the controller whether a byte is a command or data. Instead, every byte goes out as a nine-bit word. A leading flag bit marks it as a command or as data, and the eight payload bits follow it. Upstream logic hands the block tagged bytes, each a byte plus a command/data flag, through a valid/ready stream. One flag on that stream marks the last byte of a burst.

The block keeps chip select low for the whole burst. It shifts the words out in SPI mode 0, with the clock idling low and the controller sampling on the rising edge. A burst of N words carries 9·N bits. If that count does not land on a byte boundary, the block appends filler command words, each carrying a configurable opcode (by default the "write RAM" code, so that padding leaves an ongoing RAM write undisturbed), until it does. Chip select is then released one half SCLK period after the last falling clock edge.

Back-pressure rules: `in_ready` is high only while the block is idle or is holding chip select low and waiting for the next word of an open burst. A byte is taken on a rising `clk` edge where `in_valid` and `in_ready` are both high. The source must hold the byte, its flag and `in_last` stable until that edge. Between words of an open burst, the source may leave `in_valid` low for as long as it likes.

Top module: `nbf_framer`

## Requirements
- R1: After reset, and whenever no burst is open, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `in_ready` is 1.
- R2: Each accepted byte is sent as one 9-bit word. The flag bit comes first (0 = command, 1 = data), then payload bits 7 down to 0.
- R3: SPI mode 0 timing: `sclk` is 0 whenever `cs_n` is 1, `mosi` never changes while `sclk` is high or on its rising edge, and each high phase, and each low phase inside a word, lasts HALF_CYC `clk` cycles.
- R4: After the word accepted with `in_last`=1, the block sends (8 − N mod 8) mod 8 filler words, each with flag 0 and payload FILL_OP, where N is the number of words in the burst. A burst of 8 words gets none.
- R5: `cs_n` falls when the first word of a burst is accepted and stays low through all words and padding. It rises exactly HALF_CYC `clk` cycles after the last falling `sclk` edge. `busy` is high exactly while `cs_n` is low.
- R6: `in_ready` is 0 while a word is shifting, while padding is sent and during the release delay, and an offered byte is not taken then. While an open burst waits for its next byte, `cs_n` stays 0 and `sclk` stays 0 with no edges.
- R7: A 16-byte transaction (one command followed by 15 data bytes) goes out as 144 bits with no padding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream: byte offered |
| in_ready | output | 1 | Stream: block can take a byte this cycle |
| in_data | input | 8 | Payload byte |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Byte closes the burst |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | SPI serial data, MSB first |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | High while a burst is open |

## Verification
The hardest state to reach is an open burst with nothing offered, where chip select must stay low with a silent clock. The stimulus sends a byte without the last flag, waits for `in_ready` to come back, holds `in_valid` low for 200 cycles and counts `sclk` rising edges across the wait before closing the burst. Back-pressure is reached by offering the next byte at once while the previous one is still shifting. Burst lengths of 1, 2, 3, 8 and 16 cover both padded endings and endings that need no padding.

// File: rtl/nbf_pkg.sv
package nbf_pkg;
  localparam int PAY_W  = 8;
  localparam int WORD_W = PAY_W + 1;
  localparam int MOD_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_TAIL
  } nbf_state_t;
endpackage

// File: rtl/nbf_half_timer.sv
module nbf_half_timer #(
  parameter int HALF_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(HALF_CYC));
endmodule

// File: rtl/nbf_word_shifter.sv
module nbf_word_shifter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  output logic         msb,
  output logic         last_bit
);
  localparam int BW = $clog2(W);

  logic [W-1:0]  sr;
  logic [BW-1:0] bitcnt;

  assign msb      = sr[W-1];
  assign last_bit = (bitcnt == BW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      bitcnt <= '0;
    end else if (load) begin
      sr     <= load_word;
      bitcnt <= '0;
    end else if (shift) begin
      sr     <= {sr[W-2:0], 1'b0};
      bitcnt <= bitcnt + 1'b1;
    end
  end

  p_bit_range_r2: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= BW'(W - 1));
  p_load_shift_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));
endmodule

// File: rtl/nbf_framer.sv
module nbf_framer #(
  parameter int                      HALF_CYC = 5,
  parameter logic [nbf_pkg::PAY_W-1:0] FILL_OP = 8'h5C
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [nbf_pkg::PAY_W-1:0] in_data,
  input  logic                      in_is_data,
  input  logic                      in_last,
  output logic                      sclk,
  output logic                      mosi,
  output logic                      cs_n,
  output logic                      busy
);
  import nbf_pkg::*;

  nbf_state_t        state;
  logic              last_r;
  logic [MOD_W-1:0]  word_mod;
  logic [MOD_W-1:0]  mod_next;
  logic              tick;
  logic              timer_en;
  logic              accept;
  logic              word_end;
  logic              pad_load;
  logic              sh_load;
  logic              sh_shift;
  logic              last_bit;
  logic [WORD_W-1:0] sh_word;

  assign in_ready = (state == ST_IDLE) || (state == ST_GAP);
  assign busy     = (state != ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign timer_en = (state == ST_LOW) || (state == ST_HIGH) || (state == ST_TAIL);
  assign word_end = (state == ST_HIGH) && tick && last_bit;
  assign mod_next = word_mod + 1'b1;
  assign pad_load = word_end && last_r && (mod_next != '0);
  assign sh_load  = accept || pad_load;
  assign sh_shift = (state == ST_HIGH) && tick && !last_bit;
  assign sh_word  = accept ? {in_is_data, in_data} : {1'b0, FILL_OP};

  nbf_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk (clk),
    .rst (rst),
    .en  (timer_en),
    .tick(tick)
  );

  nbf_word_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (sh_load),
    .load_word(sh_word),
    .shift    (sh_shift),
    .msb      (mosi),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      last_r   <= 1'b0;
      word_mod <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_GAP: begin
          if (accept) begin
            cs_n   <= 1'b0;
            last_r <= in_last;
            state  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            sclk  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            if (last_bit) begin
              word_mod <= mod_next;
              if (!last_r)              state <= ST_GAP;
              else if (mod_next != '0)  state <= ST_LOW;
              else                      state <= ST_TAIL;
            end else begin
              state <= ST_LOW;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (cs_n && !sclk));
  p_sclk_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  p_mosi_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  p_mosi_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));
  p_pad_done_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (word_mod == '0));
  p_busy_cs_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cs_n);
  p_idle_cs_r5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
  p_no_take_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW || state == ST_HIGH || state == ST_TAIL) |-> !in_ready);
  p_gap_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (!cs_n && !sclk));
endmodule

// File: tb/nbf_framer_tb.sv
module nbf_framer_tb;
  timeunit 1ns;
  timeprecision 1ns;

  localparam int          HALF = 5;
  localparam logic [7:0]  FILL = 8'h5C;
  localparam int          HALF_NS = HALF * 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, in_is_data, in_last;
  logic [7:0] in_data;
  logic       sclk, mosi, cs_n, busy;

  always #5 clk = ~clk;

  nbf_framer #(.HALF_CYC(HALF), .FILL_OP(FILL)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_data(in_is_data), .in_last(in_last),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  logic [8:0] exp_q[$];
  int checks = 0;
  int fails = 0;
  int burst_words = 0;
  int nb = 0;
  int burst_bits = 0;
  int rises = 0;
  bit armed = 1'b0;
  logic [8:0] sh = '0;
  time t_rise = 0;
  time t_fall = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b, input bit d, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_is_data = d; in_last = last;
  endtask

  task automatic handshake(input logic [7:0] b, input bit d, input bit last);
    while (!in_ready) @(negedge clk);
    exp_q.push_back({d, b});
    burst_words++;
    if (last) begin
      for (int k = 0; k < (8 - burst_words % 8) % 8; k++)
        exp_q.push_back({1'b0, FILL});
      burst_words = 0;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit d, input bit last);
    drive(b, d, last);
    handshake(b, d, last);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, "R4", "words left unsent", exp_q.size(), 0);
    check(cs_n == 1'b1 && sclk == 1'b0 && in_ready == 1'b1, "R1", "idle lines",
          {cs_n, sclk, in_ready}, 3'b101);
  endtask

  // Scoreboard monitor: rebuild 9-bit words at each rising sclk edge.
  always @(posedge sclk) begin
    logic [8:0] e;
    check(cs_n == 1'b0, "R5", "sclk edge outside chip select", cs_n, 0);
    if (nb != 0)
      check(int'($time - t_fall) == HALF_NS, "R3", "low phase ns", $time - t_fall, HALF_NS);
    sh = {sh[7:0], mosi};
    nb++;
    burst_bits++;
    rises++;
    t_rise = $time;
    if (nb == 9) begin
      nb = 0;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected word", sh, 0);
      end else begin
        e = exp_q.pop_front();
        check(sh == e, "R2", "word", sh, e);
      end
    end
  end

  always @(negedge sclk) begin
    if (armed) begin
      check(int'($time - t_rise) == HALF_NS, "R3", "high phase ns", $time - t_rise, HALF_NS);
      t_fall = $time;
    end
  end

  always @(posedge cs_n) begin
    if (armed) begin
      check(burst_bits % 8 == 0 && nb == 0, "R4", "burst bits mod 8", burst_bits % 8, 0);
      check(int'($time - t_fall) == HALF_NS, "R5", "release delay ns", $time - t_fall, HALF_NS);
      burst_bits = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int rc;
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_is_data = 1'b0; in_last = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    armed = 1'b1;
    @(negedge clk);
    check(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
    check(sclk == 1'b0, "R1", "reset sclk", sclk, 0);
    check(busy == 1'b0, "R1", "reset busy", busy, 0);
    check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);

    // R4: single command, seven filler words
    send(8'hAF, 1'b0, 1'b1);
    check(busy == 1'b1 && cs_n == 1'b0, "R5", "busy with cs low", {busy, cs_n}, 2'b10);
    wait_idle();

    // R2: command followed by two data bytes
    send(8'h15, 1'b0, 1'b0);
    send(8'hC3, 1'b1, 1'b0);
    send(8'h3C, 1'b1, 1'b1);
    wait_idle();

    // R4: eight words end on a byte boundary, no filler
    for (int i = 0; i < 8; i++) send(8'h80 + 8'(i), i != 0, i == 7);
    wait_idle();

    // R7: one command plus 15 data bytes
    send(8'hB3, 1'b0, 1'b0);
    for (int i = 1; i < 16; i++) send(8'(i * 17), 1'b1, i == 15);
    wait_idle();

    // R6: open burst waiting for its next byte
    send(8'h4D, 1'b0, 1'b0);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    rc = rises;
    repeat (200) @(negedge clk);
    check(cs_n == 1'b0, "R6", "cs_n during gap", cs_n, 0);
    check(sclk == 1'b0, "R6", "sclk during gap", sclk, 0);
    check(busy == 1'b1, "R6", "busy during gap", busy, 1);
    check(rises == rc, "R6", "sclk edges during gap", rises - rc, 0);
    send(8'h99, 1'b1, 1'b1);
    wait_idle();

    // R6: byte offered while previous word shifts is held off
    send(8'h12, 1'b0, 1'b0);
    drive(8'h34, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check(in_ready == 1'b0, "R6", "in_ready while shifting", in_ready, 0);
    handshake(8'h34, 1'b1, 1'b1);
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule